// File: doc/BRIEF.md
# Segment Register Load Unit

This unit loads one segment register from a 16-bit selector. It works in three CPU modes: protected, real and virtual-8086. In protected mode it reads the 8-byte descriptor one byte at a time over a byte-wide memory port. It decodes the descriptor and runs the rule set for the target, which is either a stack load or a data load. If every rule passes, it emits a one-cycle commit of the selector and its decoded cache entry. If the descriptor's accessed bit was clear, it then writes that bit back to memory. In real and virtual-8086 modes no memory is touched: the cache entry is formed from the selector itself and the privilege level is forced.

The surrounding core starts a load with a one-cycle `start_i` and waits while `busy_o` is high. Success ends with `done_o`. A failed load ends with `fault_o` plus a vector and an error code, and in that case no commit is issued.

The controller is a single state machine with these states:
- `S_IDLE` waits for `start_i`.
- `S_ROUTE` picks the mode path, handles null selectors and checks table bounds.
- `S_FETCH` reads descriptor bytes 0 to 7.
- `S_CHECK` applies the rules.
- `S_COMMIT` pulses the commit.
- `S_WBACK` writes the accessed bit back.
- `S_DONE` and `S_FAULT` each last one cycle and return to `S_IDLE`.

Its transitions are:
- IDLE→ROUTE on start.
- ROUTE→COMMIT for a real, virtual-8086 or null data load.
- ROUTE→FAULT for a null stack selector or a bounds failure.
- ROUTE→FETCH otherwise.
- FETCH→CHECK after the eighth acknowledged byte.
- CHECK→FAULT or CHECK→COMMIT.
- COMMIT→WBACK when the fetched accessed bit is 0, otherwise COMMIT→DONE.
- WBACK→DONE on acknowledge.

Top module: `seg_load_unit`

## Requirements
- R1: Selector bit 2 selects the table: 0 picks the global table (`gdt_base_i`), 1 picks the local table (`ldt_base_i`). Descriptor byte k is read at base + (selector[15:3]×8) + k, for k = 0..7.
- R2: If selector[15:3]×8+7 is greater than the chosen table limit, no byte is read. A fault with vector 13 and error code selector & 0xFFFC is raised.
- R3: A stack load (target 2) with selector[15:2] = 0 faults with vector 13 and error code 0, and reads no memory.
- R4: A stack load checks its rules in this order, and each failure raises vector 13 with code selector & 0xFFFC:
  - RPL (selector[1:0]) must equal `cpl_i`.
  - The descriptor must decode as valid.
  - {S, type} & 0x1A must equal 0x12.
  - DPL must equal `cpl_i`.
- R5: A stack load that passes the R4 checks but whose present bit (access byte bit 7) is clear faults with vector 12 and code selector & 0xFFFC.
- R6: A data load (target 0, 3, 4 or 5) with a null selector reads no memory and does not fault. It commits the selector with `seg_valid_o` = 0.
- R7: A data load faults with vector 13 in any of these cases:
  - the S bit (access bit 4) is clear;
  - the type & 0xA equals 0x8 (execute-only code);
  - the target is data or non-conforming code (type bit 3 or bit 2 clear) and either RPL or CPL is greater than DPL.

  Conforming readable code skips the privilege test.
- R8: A data load that passes R7 but is not present faults with vector 11 and code selector & 0xFFFC.
- R9: Descriptor fields are decoded as follows:
  - Byte layout: limit[15:0] comes from bytes 0–1, base[23:0] from bytes 2–4, the access byte is byte 5, limit[19:16] is byte 6 bits 3:0, G is byte 6 bit 7, and base[31:24] is byte 7.
  - With G = 1 the limit is limit<<12 | 0xFFF. The exception is expand-down data (type[3:2] = 01), which gets limit<<12 with no fill.
  - With G = 0 the 20-bit limit is used as-is.
- R10: After a protected commit whose fetched access byte has bit 0 clear, exactly one byte is written: the access byte with bit 0 set, to the descriptor address + 5. No write occurs when bit 0 was already set.
- R11: Real mode (`mode_i` = 1) reads no memory. It commits base = selector<<4, limit 0xFFFF, valid 1, access 0x93 (0x9B for target 1), and pulses `cpl_we_o` with 0.
- R12: Virtual-8086 mode (`mode_i` = 2) commits the same base and limit with access 0xF3 (0xFB for target 1). It pulses `cpl_we_o` with 3.
- R13: `busy_o` is high from the cycle after `start_i` is accepted until the unit is idle again.
  - A success ends with one `seg_we_o` pulse followed by a one-cycle `done_o`.
  - A fault gives a one-cycle `fault_o`, with no `seg_we_o` during that load, and the unit is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start a load (sampled in idle) |
| mode_i | input | 2 | 0 protected, 1 real, 2 virtual-8086 |
| target_i | input | 3 | Register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| selector_i | input | 16 | Selector to load |
| cpl_i | input | 2 | Current privilege level |
| gdt_base_i | input | AW | Global table base |
| gdt_limit_i | input | 16 | Global table limit |
| ldt_base_i | input | AW | Local table base |
| ldt_limit_i | input | 32 | Local table limit |
| mem_req_o | output | 1 | Byte request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ack_i | input | 1 | Request accepted, read byte valid |
| mem_rdata_i | input | 8 | Read byte |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished successfully |
| seg_we_o | output | 1 | Commit strobe |
| seg_idx_o | output | 3 | Register being committed |
| seg_sel_o | output | 16 | Committed selector |
| seg_base_o | output | 32 | Committed base |
| seg_limit_o | output | 32 | Committed scaled limit |
| seg_attr_o | output | 8 | Committed access byte (as fetched) |
| seg_flags_o | output | 4 | Committed byte 6 bits 7:4 |
| seg_valid_o | output | 1 | Committed cache entry valid |
| cpl_we_o | output | 1 | Privilege level update strobe |
| cpl_o | output | 2 | New privilege level |
| fault_o | output | 1 | Fault strobe |
| fault_vec_o | output | 8 | Fault vector |
| fault_code_o | output | 16 | Fault error code |

## Verification
The assertions rely on two properties of the memory side:
- `mem_ack_i` only answers a pending request, so a request must stay put, with the same address, until it is acknowledged.
- The unit's inputs are held for the length of a load.

The bench meets these as follows:
- Its byte memory acknowledges at most every other cycle, and only while `mem_req_o` is high.
- It changes `start_i` and the load parameters only at a falling edge while the unit is idle.
- It never starts a protected load of target 1, which lies outside the block's scope.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    typedef enum logic [1:0] {
        MODE_PROT = 2'd0,
        MODE_REAL = 2'd1,
        MODE_V86  = 2'd2
    } cpu_mode_e;

    localparam logic [2:0] TGT_CS = 3'd1;
    localparam logic [2:0] TGT_SS = 3'd2;

    localparam logic [7:0] VEC_NP = 8'd11;
    localparam logic [7:0] VEC_SS = 8'd12;
    localparam logic [7:0] VEC_GP = 8'd13;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic [7:0]  access;
        logic [3:0]  flags;
        logic        valid;
    } seg_cache_t;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_load_pkg::*;
(
    input  logic [63:0] raw_i,
    output seg_cache_t  cache_o
);
    logic [7:0]  by [8];
    logic [19:0] lim20;
    logic [31:0] base32;
    logic [31:0] lim_scaled;
    logic [3:0]  typ;

    always_comb begin
        for (int k = 0; k < 8; k++) by[k] = raw_i[8*k +: 8];
    end

    assign lim20      = {by[6][3:0], by[1], by[0]};
    assign base32     = {by[7], by[4], by[3], by[2]};
    assign typ        = by[5][3:0];
    assign lim_scaled = by[6][7] ? {lim20, 12'hFFF} : {12'h000, lim20};

    always_comb begin
        cache_o        = '0;
        cache_o.access = by[5];
        cache_o.flags  = by[6][7:4];
        if (by[5][4]) begin
            cache_o.base  = base32;
            cache_o.valid = 1'b1;
            if (by[6][7] && typ[3:2] == 2'b01)
                cache_o.limit = {lim20, 12'h000};
            else
                cache_o.limit = lim_scaled;
        end else begin
            unique case (typ)
                4'd1, 4'd3: begin
                    cache_o.base  = {8'h00, base32[23:0]};
                    cache_o.limit = {16'h0000, by[1], by[0]};
                    cache_o.valid = 1'b1;
                end
                4'd2: begin
                    cache_o.base  = base32;
                    cache_o.limit = {16'h0000, by[1], by[0]};
                    cache_o.valid = 1'b1;
                end
                4'd9, 4'd11: begin
                    cache_o.base  = base32;
                    cache_o.limit = lim_scaled;
                    cache_o.valid = 1'b1;
                end
                4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd14, 4'd15:
                    cache_o.valid = 1'b1;
                default: cache_o.valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/seg_rules.sv
module seg_rules
    import seg_load_pkg::*;
(
    input  logic       is_stack_i,
    input  logic [1:0] rpl_i,
    input  logic [1:0] cpl_i,
    input  seg_cache_t cache_i,
    output logic       fail_o,
    output logic [7:0] vec_o
);
    logic [4:0] styp;
    logic [1:0] dpl;
    logic       present;

    assign styp    = cache_i.access[4:0];
    assign dpl     = cache_i.access[6:5];
    assign present = cache_i.access[7];

    always_comb begin
        fail_o = 1'b1;
        vec_o  = VEC_GP;
        if (is_stack_i) begin
            if (rpl_i != cpl_i)                 vec_o = VEC_GP;
            else if (!cache_i.valid)            vec_o = VEC_GP;
            else if ((styp & 5'h1A) != 5'h12)   vec_o = VEC_GP;
            else if (dpl != cpl_i)              vec_o = VEC_GP;
            else if (!present)                  vec_o = VEC_SS;
            else                                fail_o = 1'b0;
        end else begin
            if (!cache_i.valid)                 vec_o = VEC_GP;
            else if (!styp[4] || (styp[3:0] & 4'hA) == 4'h8)
                                                vec_o = VEC_GP;
            else if ((!styp[3] || !styp[2]) && (rpl_i > dpl || cpl_i > dpl))
                                                vec_o = VEC_GP;
            else if (!present)                  vec_o = VEC_NP;
            else                                fail_o = 1'b0;
        end
    end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_load_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [2:0]    target_i,
    input  logic [15:0]   selector_i,
    input  logic [1:0]    cpl_i,
    input  logic [AW-1:0] gdt_base_i,
    input  logic [15:0]   gdt_limit_i,
    input  logic [AW-1:0] ldt_base_i,
    input  logic [31:0]   ldt_limit_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          seg_we_o,
    output logic [2:0]    seg_idx_o,
    output logic [15:0]   seg_sel_o,
    output logic [31:0]   seg_base_o,
    output logic [31:0]   seg_limit_o,
    output logic [7:0]    seg_attr_o,
    output logic [3:0]    seg_flags_o,
    output logic          seg_valid_o,
    output logic          cpl_we_o,
    output logic [1:0]    cpl_o,
    output logic          fault_o,
    output logic [7:0]    fault_vec_o,
    output logic [15:0]   fault_code_o
);
    localparam int DESC_BYTES = 8;
    localparam int CW         = $clog2(DESC_BYTES);
    localparam logic [CW-1:0] LAST_BYTE = CW'(DESC_BYTES - 1);
    localparam logic [2:0]    ACC_OFS   = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE, S_ROUTE, S_FETCH, S_CHECK, S_COMMIT, S_WBACK, S_DONE, S_FAULT
    } state_e;

    state_e state_q, state_d;

    cpu_mode_e   mode_q;
    logic [2:0]  tgt_q;
    logic [15:0] sel_q;
    logic [1:0]  cpl_q;
    logic [63:0] raw_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] dbase_q;
    seg_cache_t  cache_q, dec;
    logic [7:0]  fvec_q;
    logic [15:0] fcode_q;

    logic        is_stack, sel_null, out_of_bounds, rule_fail;
    logic [7:0]  rule_vec;
    logic [31:0] idx_off, span_end, tbl_lim;
    logic [15:0] err_code;
    logic [31:0] rm_base;

    assign is_stack      = (tgt_q == TGT_SS);
    assign sel_null      = (sel_q[15:2] == 14'd0);
    assign idx_off       = {16'h0000, sel_q[15:3], 3'b000};
    assign span_end      = idx_off + 32'd7;
    assign tbl_lim       = sel_q[2] ? ldt_limit_i : {16'h0000, gdt_limit_i};
    assign out_of_bounds = (span_end > tbl_lim);
    assign err_code      = {sel_q[15:2], 2'b00};
    assign rm_base       = {12'h000, sel_q, 4'h0};

    seg_desc_decode u_decode (.raw_i(raw_q), .cache_o(dec));

    seg_rules u_rules (
        .is_stack_i(is_stack), .rpl_i(sel_q[1:0]), .cpl_i(cpl_q),
        .cache_i(dec), .fail_o(rule_fail), .vec_o(rule_vec)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_ROUTE;
            S_ROUTE: begin
                if (mode_q != MODE_PROT)   state_d = S_COMMIT;
                else if (sel_null)         state_d = is_stack ? S_FAULT : S_COMMIT;
                else if (out_of_bounds)    state_d = S_FAULT;
                else                       state_d = S_FETCH;
            end
            S_FETCH:  if (mem_ack_i && cnt_q == LAST_BYTE) state_d = S_CHECK;
            S_CHECK:  state_d = rule_fail ? S_FAULT : S_COMMIT;
            S_COMMIT: state_d = (mode_q == MODE_PROT && !sel_null && !raw_q[40])
                                ? S_WBACK : S_DONE;
            S_WBACK:  if (mem_ack_i) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            S_FAULT:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_PROT;
            tgt_q   <= '0;
            sel_q   <= '0;
            cpl_q   <= '0;
            raw_q   <= '0;
            cnt_q   <= '0;
            dbase_q <= '0;
            cache_q <= '0;
            fvec_q  <= '0;
            fcode_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    mode_q <= cpu_mode_e'(mode_i);
                    tgt_q  <= target_i;
                    sel_q  <= selector_i;
                    cpl_q  <= cpl_i;
                    cnt_q  <= '0;
                end
                S_ROUTE: begin
                    dbase_q <= (sel_q[2] ? ldt_base_i : gdt_base_i) + AW'(idx_off);
                    fvec_q  <= VEC_GP;
                    fcode_q <= (sel_null && is_stack) ? 16'h0000 : err_code;
                    if (mode_q == MODE_REAL)
                        cache_q <= '{base: rm_base, limit: 32'h0000FFFF,
                                     access: (tgt_q == TGT_CS) ? 8'h9B : 8'h93,
                                     flags: 4'h0, valid: 1'b1};
                    else if (mode_q != MODE_PROT)
                        cache_q <= '{base: rm_base, limit: 32'h0000FFFF,
                                     access: (tgt_q == TGT_CS) ? 8'hFB : 8'hF3,
                                     flags: 4'h0, valid: 1'b1};
                    else
                        cache_q <= '0;
                end
                S_FETCH: if (mem_ack_i) begin
                    raw_q[8*cnt_q +: 8] <= mem_rdata_i;
                    cnt_q <= cnt_q + 1'b1;
                end
                S_CHECK: begin
                    cache_q <= dec;
                    fvec_q  <= rule_vec;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != S_IDLE);
        done_o       = (state_q == S_DONE);
        fault_o      = (state_q == S_FAULT);
        seg_we_o     = (state_q == S_COMMIT);
        mem_req_o    = (state_q == S_FETCH) || (state_q == S_WBACK);
        mem_we_o     = (state_q == S_WBACK);
        mem_addr_o   = dbase_q + AW'((state_q == S_WBACK) ? ACC_OFS : 3'(cnt_q));
        mem_wdata_o  = raw_q[47:40] | 8'h01;
        cpl_we_o     = (state_q == S_COMMIT) && (mode_q != MODE_PROT);
        cpl_o        = (mode_q == MODE_REAL) ? 2'd0 : 2'd3;
        seg_idx_o    = tgt_q;
        seg_sel_o    = sel_q;
        seg_base_o   = cache_q.base;
        seg_limit_o  = cache_q.limit;
        seg_attr_o   = cache_q.access;
        seg_flags_o  = cache_q.flags;
        seg_valid_o  = cache_q.valid;
        fault_vec_o  = fvec_q;
        fault_code_o = fcode_q;
    end

    // assertions
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
    p_code_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> fault_code_o[1:0] == 2'b00);
    p_ss_only_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o && fault_vec_o == VEC_SS |-> seg_idx_o == TGT_SS);
    p_null_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seg_we_o && !seg_valid_o |-> seg_sel_o[15:2] == 14'd0);
    p_wb_sets_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> mem_wdata_o[0]);
    p_cpl_with_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_we_o |-> seg_we_o);
    p_fault_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !busy_o && !seg_we_o && !fault_o);
endmodule

// File: tb/test_seg_load_unit.sv
`timescale 1ns/1ps
module test_seg_load_unit;
    localparam int AW = 32;
    localparam int NV = 26;

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  tgt;
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic [7:0]  vec;
        logic [15:0] code;
        logic [31:0] base;
        logic [31:0] lim;
        logic [7:0]  attr;
        logic        valid;
        logic        wb;
        logic [2:0]  cplx;
        logic [3:0]  reads;
    } vec_t;

    // mode 0 prot 1 real 2 v86; tgt 0 ES 1 CS 2 SS 3 DS 4 FS 5 GS
    localparam vec_t VT [NV] = '{
        '{2'd0,3'd3,16'h0008,2'd0,8'd0, 16'h0000,32'h12345678,32'h000ABCDE,8'h92,1'b1,1'b1,3'b000,4'd8}, // R9
        '{2'd0,3'd3,16'h0008,2'd0,8'd0, 16'h0000,32'h12345678,32'h000ABCDE,8'h93,1'b1,1'b0,3'b000,4'd8}, // R10
        '{2'd0,3'd0,16'h0010,2'd0,8'd0, 16'h0000,32'h00100000,32'h00012FFF,8'h93,1'b1,1'b0,3'b000,4'd8}, // R9
        '{2'd0,3'd4,16'h0018,2'd0,8'd0, 16'h0000,32'h00000000,32'h00FFF000,8'h96,1'b1,1'b1,3'b000,4'd8}, // R9
        '{2'd0,3'd5,16'h0020,2'd0,8'd13,16'h0020,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R7
        '{2'd0,3'd3,16'h0028,2'd0,8'd11,16'h0028,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R8
        '{2'd0,3'd3,16'h0033,2'd3,8'd0, 16'h0000,32'h00000000,32'h000FFFFF,8'h9E,1'b1,1'b1,3'b000,4'd8}, // R7
        '{2'd0,3'd3,16'h003B,2'd3,8'd13,16'h0038,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R7
        '{2'd0,3'd3,16'h0040,2'd0,8'd13,16'h0040,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd0},             // R2
        '{2'd0,3'd0,16'h0007,2'd3,8'd0, 16'h0000,32'hCAFE0000,32'h0000FFFF,8'hF2,1'b1,1'b1,3'b000,4'd8}, // R1
        '{2'd0,3'd3,16'h000F,2'd3,8'd13,16'h000C,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R7
        '{2'd0,3'd2,16'h0007,2'd3,8'd0, 16'h0000,32'hCAFE0000,32'h0000FFFF,8'hF3,1'b1,1'b0,3'b000,4'd8}, // R4
        '{2'd0,3'd2,16'h0006,2'd3,8'd13,16'h0004,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R4
        '{2'd0,3'd2,16'h0017,2'd3,8'd13,16'h0014,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R4
        '{2'd0,3'd2,16'h001F,2'd3,8'd12,16'h001C,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R5
        '{2'd0,3'd2,16'h0000,2'd0,8'd13,16'h0000,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd0},             // R3
        '{2'd0,3'd3,16'h0003,2'd0,8'd0, 16'h0000,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd0},             // R6
        '{2'd0,3'd2,16'h0008,2'd0,8'd0, 16'h0000,32'h12345678,32'h000ABCDE,8'h93,1'b1,1'b0,3'b000,4'd8}, // R4
        '{2'd0,3'd2,16'h0013,2'd3,8'd13,16'h0010,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R4
        '{2'd0,3'd3,16'h000B,2'd0,8'd13,16'h0008,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R7
        '{2'd0,3'd2,16'h001E,2'd2,8'd13,16'h001C,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd8},             // R4
        '{2'd0,3'd3,16'h0027,2'd3,8'd13,16'h0024,32'h0,32'h0,8'h00,1'b0,1'b0,3'b000,4'd0},             // R2
        '{2'd1,3'd3,16'h1234,2'd3,8'd0, 16'h0000,32'h00012340,32'h0000FFFF,8'h93,1'b1,1'b0,3'b100,4'd0}, // R11
        '{2'd1,3'd1,16'hFFFF,2'd0,8'd0, 16'h0000,32'h000FFFF0,32'h0000FFFF,8'h9B,1'b1,1'b0,3'b100,4'd0}, // R11
        '{2'd2,3'd1,16'hF000,2'd0,8'd0, 16'h0000,32'h000F0000,32'h0000FFFF,8'hFB,1'b1,1'b0,3'b111,4'd0}, // R12
        '{2'd2,3'd3,16'h0010,2'd0,8'd0, 16'h0000,32'h00000100,32'h0000FFFF,8'hF3,1'b1,1'b0,3'b111,4'd0}  // R12
    };
    string TAG [NV] = '{"R9","R10","R9","R9","R7","R8","R7","R7","R2","R1","R7","R4","R4",
                         "R4","R5","R3","R6","R4","R4","R7","R4","R2","R11","R11","R12","R12"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = '0;
    logic [2:0]    target_i = '0;
    logic [15:0]   selector_i = '0;
    logic [1:0]    cpl_i = '0;
    logic [AW-1:0] gdt_base_i = 32'h00;
    logic [15:0]   gdt_limit_i = 16'h003F;
    logic [AW-1:0] ldt_base_i = 32'h80;
    logic [31:0]   ldt_limit_i = 32'h1F;
    logic          mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_wdata_o, mem_rdata_i = '0;
    logic          busy_o, done_o, seg_we_o, seg_valid_o, cpl_we_o, fault_o;
    logic [2:0]    seg_idx_o;
    logic [15:0]   seg_sel_o, fault_code_o;
    logic [31:0]   seg_base_o, seg_limit_o;
    logic [7:0]    seg_attr_o, fault_vec_o;
    logic [3:0]    seg_flags_o;
    logic [1:0]    cpl_o;

    logic [7:0] mem [256];
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    seg_load_unit #(.AW(AW)) i_seg_load_unit (
        .clk, .rst_n, .start_i, .mode_i, .target_i, .selector_i, .cpl_i,
        .gdt_base_i, .gdt_limit_i, .ldt_base_i, .ldt_limit_i,
        .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
        .busy_o, .done_o, .seg_we_o, .seg_idx_o, .seg_sel_o, .seg_base_o,
        .seg_limit_o, .seg_attr_o, .seg_flags_o, .seg_valid_o, .cpl_we_o, .cpl_o,
        .fault_o, .fault_vec_o, .fault_code_o
    );

    // behavioural byte memory: acknowledges a pending request every other cycle
    initial forever begin
        @(posedge clk);
        if (mem_req_o && !mem_ack_i) begin
            mem_ack_i   <= 1'b1;
            mem_rdata_i <= mem[mem_addr_o[7:0]];
            if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        end else begin
            mem_ack_i <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put_desc(input int addr, input logic [31:0] base,
                            input logic [19:0] lim, input logic [7:0] acc, input logic g);
        mem[addr+0] = lim[7:0];
        mem[addr+1] = lim[15:8];
        mem[addr+2] = base[7:0];
        mem[addr+3] = base[15:8];
        mem[addr+4] = base[23:16];
        mem[addr+5] = acc;
        mem[addr+6] = {g, 3'b000, lim[19:16]};
        mem[addr+7] = base[31:24];
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        int reads, writes, commits, faults, dones, cplw, cyc, daddr;
        logic [31:0] s_base, s_lim;
        logic [15:0] s_sel, f_code;
        logic [7:0]  s_attr, f_vec;
        logic [2:0]  s_idx;
        logic [1:0]  s_cpl;
        logic        s_valid;
        bit          fin;
        v = VT[i];
        reads = 0; writes = 0; commits = 0; faults = 0; dones = 0; cplw = 0; fin = 0;
        s_base = '0; s_lim = '0; s_sel = '0; s_attr = '0; s_idx = '0; s_valid = 0;
        s_cpl = '0; f_code = '0; f_vec = '0;
        @(negedge clk);
        mode_i = v.mode; target_i = v.tgt; selector_i = v.sel; cpl_i = v.cpl;
        start_i = 1'b1;
        for (cyc = 0; cyc < 60 && !fin; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (mem_ack_i && mem_req_o && !mem_we_o) reads++;
            if (mem_ack_i && mem_req_o && mem_we_o) writes++;
            if (seg_we_o) begin
                commits++; s_base = seg_base_o; s_lim = seg_limit_o; s_sel = seg_sel_o;
                s_attr = seg_attr_o; s_idx = seg_idx_o; s_valid = seg_valid_o;
            end
            if (cpl_we_o) begin cplw++; s_cpl = cpl_o; end
            if (fault_o) begin faults++; f_vec = fault_vec_o; f_code = fault_code_o; end
            if (done_o) dones++;
            if (done_o || fault_o) fin = 1;
        end
        check(fin, TAG[i], "load finished (R13)", 32'(fin), 32'd1);
        @(negedge clk);
        check(!busy_o && !fault_o && !done_o, TAG[i], "idle after end (R13)", 32'(busy_o), 32'd0);
        check(reads == int'(v.reads), TAG[i], "descriptor reads", 32'(reads), 32'(v.reads));
        if (v.vec != 0) begin
            check(faults == 1 && f_vec == v.vec, TAG[i], "fault vector", 32'(f_vec), 32'(v.vec));
            check(f_code == v.code, TAG[i], "fault code", 32'(f_code), 32'(v.code));
            check(commits == 0 && dones == 0, TAG[i], "no commit on fault (R13)", 32'(commits), 32'd0);
        end else begin
            check(faults == 0 && dones == 1 && commits == 1, TAG[i], "one commit then done (R13)",
                  32'(commits), 32'd1);
            check(s_sel == v.sel && s_idx == v.tgt, TAG[i], "committed selector", 32'(s_sel), 32'(v.sel));
            check(s_valid == v.valid, TAG[i], "cache valid", 32'(s_valid), 32'(v.valid));
            check(s_base == v.base, TAG[i], "base", s_base, v.base);
            check(s_lim == v.lim, TAG[i], "limit", s_lim, v.lim);
            check(s_attr == v.attr, TAG[i], "access byte", 32'(s_attr), 32'(v.attr));
        end
        check(writes == int'(v.wb), TAG[i], "accessed writeback count (R10)", 32'(writes), 32'(v.wb));
        if (v.wb) begin
            daddr = (v.sel[2] ? 'h80 : 'h00) + int'(v.sel[15:3]) * 8 + 5;
            check(mem[daddr] == (v.attr | 8'h01), TAG[i], "written accessed byte (R10)",
                  32'(mem[daddr]), 32'(v.attr | 8'h01));
        end
        check(cplw == int'(v.cplx[2]) && (!v.cplx[2] || s_cpl == v.cplx[1:0]), TAG[i],
              "privilege update", 32'(s_cpl), 32'(v.cplx[1:0]));
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        put_desc('h08, 32'h12345678, 20'hABCDE, 8'h92, 1'b0);
        put_desc('h10, 32'h00100000, 20'h00012, 8'h93, 1'b1);
        put_desc('h18, 32'h00000000, 20'h00FFF, 8'h96, 1'b1);
        put_desc('h20, 32'h00000000, 20'hFFFFF, 8'h98, 1'b0);
        put_desc('h28, 32'h00000000, 20'hFFFFF, 8'h12, 1'b0);
        put_desc('h30, 32'h00000000, 20'hFFFFF, 8'h9E, 1'b0);
        put_desc('h38, 32'h00000000, 20'hFFFFF, 8'h9A, 1'b0);
        put_desc('h80, 32'hCAFE0000, 20'h0FFFF, 8'hF2, 1'b0);
        put_desc('h88, 32'h00000000, 20'h000FF, 8'h82, 1'b0);
        put_desc('h90, 32'h00000000, 20'hFFFFF, 8'hF0, 1'b0);
        put_desc('h98, 32'h00000000, 20'hFFFFF, 8'h72, 1'b0);
        repeat (3) @(negedge clk);
        // reset state (R13)
        check(!busy_o && !done_o && !fault_o && !seg_we_o && !mem_req_o && !cpl_we_o,
              "R13", "outputs quiet in reset", 32'(busy_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !mem_req_o, "R13", "idle after reset", 32'(busy_o), 32'd0);
        for (int i = 0; i < NV; i++) run_vec(i);
        // directed: accessed byte of an already-accessed descriptor unchanged (R10)
        check(mem['h08 + 5] == 8'h93, "R10", "byte 5 kept after second load", 32'(mem['h0D]), 32'h93);
        // directed: descriptor at the very end of the global table is within bounds (R2)
        check(mem['h38 + 5] == 8'h9A, "R2", "last entry fetched, no writeback on fault",
              32'(mem['h3D]), 32'h9A);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL R13 watchdog expired actual=%h expected=%h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule